// File: doc/BRIEF.md
# Three-Key Keypad Sequence Lock

This controller watches a keypad and opens a door only after one particular three-key combination. Each key press is given to it as a one-cycle strobe, along with two lines that say which of the two keys was hit. All inputs are already synchronous to the clock. The password is a three-symbol parameter, and by default it is key B, then key A, then key B.

The state lives in a three-bit register, and every output is decoded from that state alone, so this is a Moore machine. An attempt is always exactly three presses long. After the first wrong key the machine moves onto a separate chain of failure states. That chain still counts presses, so the display keeps advancing, but it can never reach the unlock state. After the third press the machine shows a count of three for one cycle and then goes back to idle by itself. When all three keys were correct, the unlock pulse is high in that same cycle.

Top module: `keypad_seq_lock`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle. Idle shows zero presses (press_onehot = 4'b0001) with unlock low.
- R2: press_onehot is always one-hot. Bit 0 means zero presses in the current attempt, bit 1 one press, bit 2 two presses and bit 3 three presses.
- R3: While key_valid is low, and the machine is not in a third-press state, the state holds and the display does not change.
- R4: Entering key B, key A and key B as three presses makes unlock high for exactly one cycle. That cycle is the one right after the clock edge that samples the third press, and the display shows bit 3 in it.
- R5: If any of the three presses is wrong, unlock stays low for the whole attempt. The display still advances by one bit position on each press.
- R6: A key is A when key_valid=1, key_a=1, key_b=0. A key is B when key_valid=1, key_a=0, key_b=1. When key_valid=1 with key_a and key_b both high or both low, the press counts as a wrong key.
- R7: In the cycle after the third press, the machine returns to idle whatever the inputs are. A key strobe given during that cycle is ignored.
- R8: A wrong key does not end the attempt early. Only after three presses does a new attempt begin, and its first press shows as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | One-cycle strobe: a key was pressed |
| key_a | input | 1 | Identity line for key A |
| key_b | input | 1 | Identity line for key B |
| unlock | output | 1 | One-cycle pulse that opens the door |
| press_onehot | output | 4 | One-hot count of presses in the current attempt |

## Verification
The assertions assume that each press raises key_valid for one cycle only and that all inputs change away from the sampling edge. Under those assumptions, every strobe that is not in a third-press cycle advances the count by exactly one position. The bench drives every input on the falling edge. Its press task lowers key_valid again one cycle later, and it adds idle cycles between presses. The only deliberate back-to-back strobe is the one that checks that a key given during the third-press cycle is ignored.

// File: rtl/lock_pkg.sv
package lock_pkg;
    // Three-bit state encoding; bit 2 marks the failure chain.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_G1   = 3'd1,
        ST_G2   = 3'd2,
        ST_G3   = 3'd3,
        ST_X1   = 3'd5,
        ST_X2   = 3'd6,
        ST_X3   = 3'd7
    } lock_state_e;

    typedef struct packed {
        lock_state_e st;
    } lock_regs_t;

    localparam int unsigned CODE_LEN = 3;
    localparam int unsigned DISP_W   = CODE_LEN + 1;
endpackage

// File: rtl/lock_key_match.sv
module lock_key_match
    import lock_pkg::*;
#(
    parameter logic [CODE_LEN-1:0] CODE = 3'b101  // bit i = expected key of press i, 1 = B
) (
    input  lock_state_e st,
    input  logic        key_valid,
    input  logic        key_a,
    input  logic        key_b,
    output logic        hit
);
    logic is_a;
    logic is_b;
    logic want_b;

    always_comb begin
        is_a = key_valid & key_a & ~key_b;
        is_b = key_valid & key_b & ~key_a;
        case (st)
            ST_G1:   want_b = CODE[1];
            ST_G2:   want_b = CODE[2];
            default: want_b = CODE[0];
        endcase
        hit = want_b ? is_b : is_a;
    end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
    import lock_pkg::*;
(
    input  lock_state_e st,
    input  logic        key_valid,
    input  logic        hit,
    output lock_state_e st_nxt
);
    always_comb begin
        st_nxt = st;
        case (st)
            ST_IDLE: if (key_valid) st_nxt = hit ? ST_G1 : ST_X1;
            ST_G1:   if (key_valid) st_nxt = hit ? ST_G2 : ST_X2;
            ST_G2:   if (key_valid) st_nxt = hit ? ST_G3 : ST_X3;
            ST_X1:   if (key_valid) st_nxt = ST_X2;
            ST_X2:   if (key_valid) st_nxt = ST_X3;
            ST_G3,
            ST_X3:   st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/lock_out_decode.sv
module lock_out_decode
    import lock_pkg::*;
(
    input  lock_state_e        st,
    output logic               unlock,
    output logic [DISP_W-1:0]  press_onehot
);
    always_comb begin
        unlock = (st == ST_G3);
        case (st)
            ST_G1, ST_X1: press_onehot = 4'b0010;
            ST_G2, ST_X2: press_onehot = 4'b0100;
            ST_G3, ST_X3: press_onehot = 4'b1000;
            default:      press_onehot = 4'b0001;
        endcase
    end
endmodule

// File: rtl/keypad_seq_lock.sv
module keypad_seq_lock
    import lock_pkg::*;
#(
    parameter logic [CODE_LEN-1:0] CODE = 3'b101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_valid,
    input  logic              key_a,
    input  logic              key_b,
    output logic              unlock,
    output logic [DISP_W-1:0] press_onehot
);
    lock_regs_t  regs_d;
    lock_regs_t  regs_q;
    lock_state_e st_nxt;
    logic        hit;

    lock_key_match #(.CODE(CODE)) u_match (
        .st        (regs_q.st),
        .key_valid (key_valid),
        .key_a     (key_a),
        .key_b     (key_b),
        .hit       (hit)
    );

    lock_next_state u_next (
        .st        (regs_q.st),
        .key_valid (key_valid),
        .hit       (hit),
        .st_nxt    (st_nxt)
    );

    lock_out_decode u_out (
        .st           (regs_q.st),
        .unlock       (unlock),
        .press_onehot (press_onehot)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q.st <= ST_IDLE;
        else     regs_q    <= regs_d;
    end
endmodule

// File: rtl/lock_checker.sv
module lock_checker (
    input logic       clk,
    input logic       rst,
    input logic       key_valid,
    input logic       unlock,
    input logic [3:0] press_onehot
);
    // R1: reset leads to idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (press_onehot == 4'b0001 && !unlock));

    // R2: display is one-hot
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(press_onehot) == 1);

    // R3: no key, not finishing -> hold
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!key_valid && !press_onehot[3]) |=> $stable(press_onehot));

    // R4: unlock lasts one cycle and shows three presses
    a_r4_pulse: assert property (@(posedge clk) disable iff (rst)
        unlock |=> !unlock);
    a_r4_count3: assert property (@(posedge clk) disable iff (rst)
        unlock |-> press_onehot[3]);
    a_r4_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock) |-> $past(key_valid));

    // R5: each press advances the count
    a_r5_advance: assert property (@(posedge clk) disable iff (rst)
        (key_valid && press_onehot[1]) |=> press_onehot[2]);

    // R7: third-press cycle returns to idle
    a_r7_return: assert property (@(posedge clk) disable iff (rst)
        press_onehot[3] |=> press_onehot[0]);
endmodule

bind keypad_seq_lock lock_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .key_valid    (key_valid),
    .unlock       (unlock),
    .press_onehot (press_onehot)
);

// File: tb/sim_keypad_seq_lock.sv
module sim_keypad_seq_lock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_valid = 1'b0;
    logic       key_a = 1'b0;
    logic       key_b = 1'b0;
    logic       unlock;
    logic [3:0] press_onehot;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    keypad_seq_lock u0 (
        .clk          (clk),
        .rst          (rst),
        .key_valid    (key_valid),
        .key_a        (key_a),
        .key_b        (key_b),
        .unlock       (unlock),
        .press_onehot (press_onehot)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic u_exp, input logic [3:0] d_exp);
        vectors++;
        if (unlock !== u_exp || press_onehot !== d_exp) begin
            errors++;
            $display("FAIL %s: unlock=%b disp=%b expected unlock=%b disp=%b",
                     req, unlock, press_onehot, u_exp, d_exp);
        end
    endtask

    // Drive a strobe at a falling edge; at the next falling edge the state has
    // taken the press, and key_valid is dropped there.
    task automatic press(input logic a, input logic b);
        @(negedge clk);
        key_valid = 1'b1; key_a = a; key_b = b;
        @(negedge clk);
        key_valid = 1'b0; key_a = 1'b0; key_b = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check("R1 reset", 1'b0, 4'b0001);
    endtask

    task automatic t_good_sequence;
        press(1'b0, 1'b1); check("R2 one press", 1'b0, 4'b0010);
        idle(3);           check("R3 hold", 1'b0, 4'b0010);
        press(1'b1, 1'b0); check("R2 two presses", 1'b0, 4'b0100);
        press(1'b0, 1'b1); check("R4 unlock pulse", 1'b1, 4'b1000);
        idle(1);           check("R4 single cycle / R7 idle", 1'b0, 4'b0001);
        idle(2);           check("R3 idle hold", 1'b0, 4'b0001);
    endtask

    task automatic t_wrong_key(input int pos);
        for (int i = 0; i < 3; i++) begin
            logic wa, wb;
            wb = (i != 1);
            wa = (i == 1);
            if (i == pos) begin wa = ~wa; wb = ~wb; end
            press(wa, wb);
            check("R5 wrong key counts", 1'b0, 4'b0010 << i);
        end
        idle(1); check("R5 no unlock after", 1'b0, 4'b0001);
    endtask

    task automatic t_odd_codes;
        press(1'b1, 1'b1); check("R6 both lines", 1'b0, 4'b0010);
        press(1'b1, 1'b0); check("R6 chain", 1'b0, 4'b0100);
        press(1'b0, 1'b1); check("R6 no unlock", 1'b0, 4'b1000);
        idle(1);
        press(1'b0, 1'b1);
        press(1'b0, 1'b0); check("R6 neither line", 1'b0, 4'b0100);
        press(1'b0, 1'b1); check("R6 no unlock", 1'b0, 4'b1000);
        idle(1);
    endtask

    task automatic t_ignore_after_third;
        press(1'b0, 1'b1);
        press(1'b1, 1'b0);
        @(negedge clk);
        key_valid = 1'b1; key_b = 1'b1;
        @(negedge clk);
        // third press taken; strobe again in the third-press cycle
        check("R7 third press unlocks", 1'b1, 4'b1000);
        @(negedge clk);
        key_valid = 1'b0; key_b = 1'b0;
        check("R7 strobe ignored", 1'b0, 4'b0001);
        idle(1);
    endtask

    task automatic t_no_early_end;
        press(1'b1, 1'b0);
        press(1'b0, 1'b1);
        press(1'b1, 1'b0); check("R8 full attempt", 1'b0, 4'b1000);
        press(1'b0, 1'b1); check("R8 new attempt count one", 1'b0, 4'b0010);
        press(1'b1, 1'b0);
        press(1'b0, 1'b1); check("R8 fresh attempt unlocks", 1'b1, 4'b1000);
        idle(1);
        press(1'b0, 1'b1);
        rst = 1'b1; idle(1); rst = 1'b0;
        check("R1 reset mid attempt", 1'b0, 4'b0001);
    endtask

    initial begin
        t_reset();
        t_good_sequence();
        t_wrong_key(0);
        t_wrong_key(1);
        t_wrong_key(2);
        t_odd_codes();
        t_ignore_after_third();
        t_no_early_end();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule